// File: doc/BRIEF.md
# Programmable Periodic Interval Timer

This block raises a periodic level interrupt. Its period is a whole number of milliseconds. A one-cycle tick input, pulsed once per millisecond by logic outside the block, advances an internal counter. When the counter has passed the programmed reload value, one period is complete: the interrupt goes high and the next period begins on the same tick.

Software controls the block through a 32-bit register port that has one write strobe and one read strobe.
- A write to the reload register sets the new period. It also drops the interrupt and restarts the current period from zero.
- A read of the count register returns how many milliseconds of the current period have elapsed. The same read acknowledges the interrupt.

Top module: `ivl_timer`

## Requirements
- R1: After reset the interrupt output is low, the reload value is 0 and a read of the count register returns 0.
- R2: Let the reload value be N. After a reload write, the interrupt rises on the clock edge that samples the (N+1)-th tick pulse. With the reset value 0, one tick is enough.
- R3: A write to address 0x228 does three things: it stores the full 32-bit write data as the reload value, it lowers the interrupt and it sets the count to 0. A tick pulse in the same cycle as the write is discarded.
- R4: A read is rd_en high with address 0x230. During the read, rdata carries the current count, combinationally. On the next clock edge the interrupt is lowered.
- R5: If a period expires in the same cycle as an acknowledging read, the interrupt stays high.
- R6: The count changes only on a tick pulse. Each tick adds one, and the tick that completes a period sets the count back to 0.
- R7: Reads at any other address return 0 and leave the interrupt unchanged. Writes at any other address leave the reload value and the count unchanged.
- R8: The interrupt is a level. Once raised, it stays high through later ticks and later periods until a count read or a reload write clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| irq | output | 1 | Level interrupt |

## Verification
A table of reload values is applied, from 0 through 16, including the smallest periods of one and two ticks. For each value, the bench counts the ticks it takes for the interrupt to rise. This separates an off-by-one period, a counter that fails to wrap and a reload that was stored wrongly.

Directed cases then place events together in one cycle:
- a tick together with a reload write, which shows whether the restart takes priority;
- an expiry together with an acknowledging read, which shows whether the expiry wins;
- accesses at addresses next to the two registers, which show whether the address decode is exact.

Idle stretches with no tick, and ticks that continue after the interrupt is raised, tell a held count from a free-running one and a level interrupt from a pulse.

// File: rtl/ivl_timer_pkg.sv
`timescale 1ns/1ps
package ivl_timer_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] RELOAD_OFS = 12'h228;
    localparam logic [ADDR_W-1:0] COUNT_OFS  = 12'h230;

    typedef struct packed {
        logic irq;
    } irq_state_t;
endpackage

// File: rtl/ivl_timer_decode.sv
`timescale 1ns/1ps
module ivl_timer_decode #(
    parameter int AW = 12,
    parameter logic [AW-1:0] LOAD_ADDR = 12'h228,
    parameter logic [AW-1:0] CNT_ADDR  = 12'h230
) (
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    output logic          load,
    output logic          ack,
    output logic          sel_count
);
    always_comb begin
        sel_count = rd_en && (addr == CNT_ADDR);
        ack       = sel_count;
        load      = wr_en && (addr == LOAD_ADDR);
    end
endmodule

// File: rtl/ivl_timer_count.sv
`timescale 1ns/1ps
module ivl_timer_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic [W-1:0] reload,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] reload;
        logic [W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       expire_d;

    always_comb begin
        st_d     = st_q;
        expire_d = 1'b0;
        if (load) begin
            st_d.reload = load_val;
            st_d.count  = '0;
        end else if (tick) begin
            if (st_q.count == st_q.reload) begin
                st_d.count = '0;
                expire_d   = 1'b1;
            end else begin
                st_d.count = st_q.count + ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count  = st_q.count;
    assign reload = st_q.reload;
    assign expire = expire_d;
endmodule

// File: rtl/ivl_timer_irq.sv
`timescale 1ns/1ps
module ivl_timer_irq
    import ivl_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic ack,
    input  logic expire,
    output logic irq
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.irq = 1'b0;
        end else if (expire) begin
            st_d.irq = 1'b1;
        end else if (ack) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/ivl_timer.sv
`timescale 1ns/1ps
module ivl_timer
    import ivl_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick_ms,
    output logic              irq
);
    logic              load;
    logic              ack;
    logic              sel_count;
    logic              expire;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] reload;

    ivl_timer_decode #(
        .AW       (ADDR_W),
        .LOAD_ADDR(RELOAD_OFS),
        .CNT_ADDR (COUNT_OFS)
    ) u_dec (
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .load     (load),
        .ack      (ack),
        .sel_count(sel_count)
    );

    ivl_timer_count #(.W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_ms),
        .load    (load),
        .load_val(wdata),
        .count   (count),
        .reload  (reload),
        .expire  (expire)
    );

    ivl_timer_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .ack   (ack),
        .expire(expire),
        .irq   (irq)
    );

    assign rdata = sel_count ? count : '0;
endmodule

// File: rtl/ivl_timer_chk.sv
`timescale 1ns/1ps
module ivl_timer_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_ms,
    input logic         load,
    input logic         ack,
    input logic         expire,
    input logic [W-1:0] count,
    input logic [W-1:0] reload,
    input logic         irq
);
    AST_IRQ_LOW_AT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq); // R1
    AST_EXPIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (irq && count == '0)); // R2
    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!irq && count == '0)); // R3
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !expire && !load) |=> !irq); // R4
    AST_EXPIRE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && expire) |=> irq); // R5
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_ms && !load) |=> ($stable(count) && $stable(reload))); // R6
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count <= reload); // R6
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack && !load) |=> irq); // R8
endmodule

bind ivl_timer ivl_timer_chk #(.W(ivl_timer_pkg::DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_ms(tick_ms),
    .load   (load),
    .ack    (ack),
    .expire (expire),
    .count  (count),
    .reload (reload),
    .irq    (irq)
);

// File: tb/tb_ivl_timer.sv
`timescale 1ns/1ps
module tb_ivl_timer;
    localparam logic [11:0] A_RLD = 12'h228;
    localparam logic [11:0] A_CNT = 12'h230;
    localparam int NV = 6;
    localparam logic [31:0] VEC_RLD [NV] = '{32'd0, 32'd1, 32'd2, 32'd5, 32'd9, 32'd16};
    localparam int          VEC_EXP [NV] = '{1, 2, 3, 6, 10, 17};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick_ms = 1'b0;
    logic        irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ivl_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_ms(tick_ms), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [11:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; tick_ms = tk;
        @(negedge clk);
        wr_en = 1'b0; tick_ms = 1'b0; addr = '0;
    endtask

    task automatic do_rd(input logic [11:0] a, input logic tk, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a; tick_ms = tk;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0; tick_ms = 1'b0; addr = '0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick_ms = 1'b1;
        @(negedge clk);
        tick_ms = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        #(64'd20 * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int n;
        idle(3);
        chk("R1 irq in reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        idle(1);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        do_rd(A_CNT, 1'b0, rd);
        chk("R1 count after reset", rd, 32'd0);
        do_tick();
        chk("R2 default period one tick", {31'd0, irq}, 32'd1);
        do_rd(A_CNT, 1'b0, rd);
        chk("R4 ack clears irq", {31'd0, irq}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            do_wr(A_RLD, VEC_RLD[v], 1'b0);
            chk("R3 irq low after reload", {31'd0, irq}, 32'd0);
            n = 0;
            while (!irq && n < 100) begin
                do_tick();
                n++;
            end
            chk("R2 ticks per period", n, VEC_EXP[v]);
            do_rd(A_CNT, 1'b0, rd);
            chk("R6 count wrapped at expiry", rd, 32'd0);
            chk("R4 irq cleared by read", {31'd0, irq}, 32'd0);
        end

        do_wr(A_RLD, 32'd9, 1'b0);
        for (int i = 0; i < 4; i++) do_tick();
        do_rd(A_CNT, 1'b0, rd);
        chk("R4 count readback", rd, 32'd4);
        idle(5);
        do_rd(A_CNT, 1'b0, rd);
        chk("R6 count holds without tick", rd, 32'd4);
        do_wr(12'h22C, 32'd0, 1'b0);
        do_wr(12'h230, 32'd1, 1'b0);
        do_rd(A_CNT, 1'b0, rd);
        chk("R7 other writes keep count", rd, 32'd4);
        for (int i = 0; i < 5; i++) do_tick();
        chk("R7 other writes keep reload", {31'd0, irq}, 32'd0);
        do_tick();
        chk("R7 period still ten ticks", {31'd0, irq}, 32'd1);

        do_rd(12'h000, 1'b0, rd);
        chk("R7 other read data", rd, 32'd0);
        do_rd(12'h228, 1'b0, rd);
        chk("R7 reload address read data", rd, 32'd0);
        chk("R7 other reads keep irq", {31'd0, irq}, 32'd1);
        for (int i = 0; i < 12; i++) do_tick();
        chk("R8 irq held across periods", {31'd0, irq}, 32'd1);
        do_rd(A_CNT, 1'b0, rd);
        chk("R6 count after twelve more ticks", rd, 32'd2);

        do_wr(A_RLD, 32'd3, 1'b0);
        do_tick();
        do_tick();
        do_wr(A_RLD, 32'd3, 1'b1);
        do_rd(A_CNT, 1'b0, rd);
        chk("R3 tick with write discarded", rd, 32'd0);
        for (int i = 0; i < 3; i++) do_tick();
        chk("R3 restart period not yet done", {31'd0, irq}, 32'd0);
        do_tick();
        chk("R3 restart period done", {31'd0, irq}, 32'd1);
        do_wr(A_RLD, 32'd0, 1'b0);
        chk("R3 write clears irq", {31'd0, irq}, 32'd0);

        do_tick();
        chk("R5 setup irq", {31'd0, irq}, 32'd1);
        do_rd(A_CNT, 1'b1, rd);
        chk("R5 expiry beats ack", {31'd0, irq}, 32'd1);
        do_rd(A_CNT, 1'b0, rd);
        chk("R4 plain ack afterwards", {31'd0, irq}, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule